// File: doc/BRIEF.md
# External interrupt pin controller

This block watches one active-low interrupt pin that arrives from outside the chip and turns it into a single interrupt request for the core. The pin is first brought into the clock domain through a short synchronizer chain. A small control register then chooses how the pin is interpreted. In level mode the request is raised for as long as the pin is held low. In edge mode each falling edge is caught in a pending latch. That latch drops only when the core pulses a service acknowledge, or when the block is reset.

Software reaches the control register over a minimal register bus with an address, a write strobe, write data and combinational read data. The control register holds an enable bit and a mode bit. When a mode input is low, the block runs in normal mode and the mode bit can be written only once after reset. When the mode input is high, the block runs in special mode and the mode bit can be rewritten freely. The address just below the control register is reserved. It reads as zero, and writes to it do nothing.

Top module: `extint_ctrl`

## Requirements
- R1: The control register sits at address CTRL_ADDR (0xE by default). Bit 7 is the mode bit (1 = falling-edge, 0 = low-level) and bit 6 is the enable bit. Bits 5..0 always read 0. Read data is combinational from busAddr in the same cycle, and any other address reads 0x00.
- R2: After reset the control register reads 0x40: level mode, enabled.
- R3: The reserved address CTRL_ADDR-1 (0xD by default) always reads 0x00. A write to it changes neither the control register nor the write-once state.
- R4: In normal mode (specialMode=0), only the first control-register write after reset updates the mode bit. Every later write leaves the mode bit unchanged until reset, and this lock survives any later change of specialMode.
- R5: In special mode (specialMode=1), every control-register write updates the mode bit, and such writes do not use up the single normal-mode write.
- R6: Every control-register write updates the enable bit, in either mode.
- R7: While the enable bit is 0, irqReq is 0.
- R8: In level mode, irqReq equals enable AND NOT the synchronized pin, with no latching. The output follows the pin two clock edges after the pin changes.
- R9: In edge mode, a falling edge of the synchronized pin sets a pending latch, and irqReq equals enable AND pending. The pin returning high does not clear the latch. A one-cycle intAck clears it.
- R10: If a new falling edge is detected in the same cycle that intAck is high, the pending latch stays set.
- R11: Falling edges are captured in edge mode even while the enable bit is 0. Setting enable afterwards raises irqReq.
- R12: Falling edges seen in level mode do not set the pending latch, and reset clears the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| specialMode | input | 1 | 1 = special mode (mode bit freely writable), 0 = normal mode |
| pinN | input | 1 | Asynchronous active-low external interrupt pin |
| busAddr | input | ADDR_W | Register address |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data |
| intAck | input | 1 | One-cycle service acknowledge for the pending latch |
| irqReq | output | 1 | Interrupt request to the core |

## Verification
The hardest case to reach from the ports is a falling edge that becomes visible after synchronization in exactly the cycle the acknowledge is sampled. The bench first leaves the latch set. It then drops the pin on a falling clock edge, waits two rising edges, and raises intAck so that the third rising edge sees both the edge and the acknowledge. The write-once lock is covered by a reset-per-case sweep over every pair of first and second normal-mode writes. Separate sequences mix special-mode writes and reserved-address writes before the first normal write.

// File: rtl/extint_pkg.sv
package extint_pkg;

  // Strobes and settings handed from the register control to the pin datapath
  typedef struct packed {
    logic edgeMode;
    logic enable;
    logic ackStb;
  } pathCtl_t;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= RESET_VAL;
        else       chain[g] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= RESET_VAL;
        else       chain[g] <= chain[g-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'hE,
  parameter int                EDGE_BIT  = 7,
  parameter int                EN_BIT    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              specialMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              intAck,
  output pathCtl_t          ctl,
  output logic              locked
);

  localparam logic [ADDR_W-1:0] RSVD_ADDR = CTRL_ADDR - ADDR_W'(1);

  logic edgeSel;
  logic enable;
  logic wrCtrl;
  logic edgeWrOk;
  logic unusedWdata;

  assign wrCtrl      = busWe && (busAddr == CTRL_ADDR);
  assign edgeWrOk    = wrCtrl && (specialMode || !locked);
  assign unusedWdata = ^busWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeSel <= 1'b0;
      enable  <= 1'b1;
      locked  <= 1'b0;
    end else begin
      if (edgeWrOk) edgeSel <= busWdata[EDGE_BIT];
      if (wrCtrl)   enable  <= busWdata[EN_BIT];
      if (wrCtrl && !specialMode) locked <= 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == CTRL_ADDR) begin
      busRdata[EDGE_BIT] = edgeSel;
      busRdata[EN_BIT]   = enable;
    end else if (busAddr == RSVD_ADDR) begin
      busRdata = '0;
    end
  end

  always_comb begin
    ctl.edgeMode = edgeSel;
    ctl.enable   = enable;
    ctl.ackStb   = intAck;
  end

endmodule

// File: rtl/extint_path.sv
module extint_path
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pinN,
  input  pathCtl_t ctl,
  output logic     irqReq,
  output logic     pending
);

  logic syncPin;
  logic prevPin;
  logic fallSeen;
  logic pendNext;

  extint_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (pinN),
    .dout(syncPin)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPin <= 1'b1;
    else       prevPin <= syncPin;
  end

  assign fallSeen = prevPin && !syncPin;
  assign pendNext = (ctl.edgeMode && fallSeen) || (pending && !ctl.ackStb);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= pendNext;
  end

  assign irqReq = ctl.enable && (ctl.edgeMode ? pending : !syncPin);

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 4'hE,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              specialMode,
  input  logic              pinN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              intAck,
  output logic              irqReq
);

  pathCtl_t pathCtl;
  logic     locked;
  logic     pending;
  logic     edgeModeQ;
  logic     enableQ;

  extint_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (8),
    .CTRL_ADDR(CTRL_ADDR),
    .EDGE_BIT (7),
    .EN_BIT   (6)
  ) uRegs (
    .clk        (clk),
    .rstN       (rstN),
    .specialMode(specialMode),
    .busAddr    (busAddr),
    .busWe      (busWe),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .intAck     (intAck),
    .ctl        (pathCtl),
    .locked     (locked)
  );

  extint_path #(
    .SYNC_STAGES(SYNC_STAGES)
  ) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .pinN   (pinN),
    .ctl    (pathCtl),
    .irqReq (irqReq),
    .pending(pending)
  );

  assign edgeModeQ = pathCtl.edgeMode;
  assign enableQ   = pathCtl.enable;

endmodule

// File: rtl/extint_chk.sv
module extint_chk #(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'hE
) (
  input logic              clk,
  input logic              rstN,
  input logic              specialMode,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [7:0]        busWdata,
  input logic [7:0]        busRdata,
  input logic              intAck,
  input logic              irqReq,
  input logic              edgeModeQ,
  input logic              enableQ,
  input logic              locked,
  input logic              pending
);

  localparam logic [ADDR_W-1:0] RSVD_ADDR = CTRL_ADDR - ADDR_W'(1);

  logic wrCtrl;
  assign wrCtrl = busWe && (busAddr == CTRL_ADDR);

  assert_low_bits_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[5:0] == 6'd0);

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == RSVD_ADDR) |-> (busRdata == 8'h00));

  assert_write_once_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !specialMode && locked) |=> $stable(edgeModeQ));

  assert_special_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && specialMode) |=> (edgeModeQ == $past(busWdata[7])));

  assert_enable_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> (enableQ == $past(busWdata[6])));

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ |-> !irqReq);

  assert_pending_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !intAck) |=> pending);

  assert_edge_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (edgeModeQ && enableQ) |-> (irqReq == pending));

endmodule

bind extint_ctrl extint_chk #(
  .ADDR_W   (ADDR_W),
  .CTRL_ADDR(CTRL_ADDR)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .specialMode(specialMode),
  .busAddr    (busAddr),
  .busWe      (busWe),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .intAck     (intAck),
  .irqReq     (irqReq),
  .edgeModeQ  (edgeModeQ),
  .enableQ    (enableQ),
  .locked     (locked),
  .pending    (pending)
);

// File: tb/tb_extint_ctrl.sv
`timescale 1ns/1ps
module tb_extint_ctrl;

  localparam logic [3:0] CTRL = 4'hE;
  localparam logic [3:0] RSVD = 4'hD;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       specialMode = 1'b0;
  logic       pinN = 1'b1;
  logic [3:0] busAddr = CTRL;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       intAck = 1'b0;
  logic       irqReq;

  int nCmp = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  extint_ctrl dut (
    .clk        (clk),
    .rstN       (rstN),
    .specialMode(specialMode),
    .pinN       (pinN),
    .busAddr    (busAddr),
    .busWe      (busWe),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .intAck     (intAck),
    .irqReq     (irqReq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; busWe = 1'b0; intAck = 1'b0; pinN = 1'b1; busAddr = CTRL;
    tick(2);
    rstN = 1'b1;
    tick(3);
  endtask

  task automatic busWrite(logic [3:0] a, logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    tick(1);
    busWe = 1'b0; busWdata = 8'h00;
  endtask

  task automatic readChk(string req, logic [3:0] a, logic [7:0] exp);
    busAddr = a;
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic irqChk(string req, logic exp);
    check(req, {7'd0, irqReq}, {7'd0, exp});
  endtask

  task automatic ackPulse();
    intAck = 1'b1;
    tick(1);
    intAck = 1'b0;
  endtask

  initial begin
    tick(1);
    doReset();

    // Reset state
    readChk("R2 reset value", CTRL, 8'h40);
    irqChk("R8 idle pin no request", 1'b0);

    // Special mode: every written value lands in bits 7..6 only
    specialMode = 1'b1;
    for (int v = 0; v < 256; v++) begin
      busWrite(CTRL, 8'(v));
      readChk("R5 R1 special write sweep", CTRL, 8'(v) & 8'hC0);
    end
    readChk("R3 reserved reads zero", RSVD, 8'h00);
    readChk("R1 unmapped reads zero", 4'h0, 8'h00);

    // Special writes must not consume the single normal write
    specialMode = 1'b0;
    busWrite(CTRL, 8'h80);
    readChk("R5 normal write after special", CTRL, 8'h80);
    busWrite(CTRL, 8'h40);
    readChk("R4 R6 second normal write", CTRL, 8'h40 | 8'h80);
    specialMode = 1'b1;
    busWrite(CTRL, 8'h00);
    readChk("R5 special overrides lock", CTRL, 8'h00);
    specialMode = 1'b0;
    busWrite(CTRL, 8'h80);
    readChk("R4 lock survives mode change", CTRL, 8'h00);

    // Normal mode write-once sweep over all first/second pairs
    for (int f = 0; f < 4; f++) begin
      for (int s = 0; s < 4; s++) begin
        specialMode = 1'b0;
        doReset();
        busWrite(CTRL, 8'(f << 6));
        readChk("R4 first normal write", CTRL, 8'(f << 6));
        busWrite(CTRL, 8'(s << 6));
        readChk("R4 R6 later normal write", CTRL,
                8'(((f >> 1) << 7) | ((s & 1) << 6)));
      end
    end

    // Reserved address writes are ignored and do not lock
    doReset();
    specialMode = 1'b1;
    busWrite(RSVD, 8'hFF);
    specialMode = 1'b0;
    busWrite(RSVD, 8'hFF);
    readChk("R3 reserved write ignored", CTRL, 8'h40);
    readChk("R3 reserved still zero", RSVD, 8'h00);
    busWrite(CTRL, 8'h80);
    readChk("R3 no lock from reserved", CTRL, 8'h80);

    // Level mode sweep
    doReset();
    specialMode = 1'b1;
    for (int en = 0; en < 2; en++) begin
      for (int p = 0; p < 2; p++) begin
        busWrite(CTRL, 8'(en << 6));
        pinN = p[0];
        tick(3);
        irqChk(en == 0 ? "R7 level disabled" : "R8 level follows pin",
               en[0] & ~p[0]);
        pinN = 1'b1;
        tick(3);
        irqChk("R8 level no latching", 1'b0);
      end
    end

    // Edge mode: latch, hold, ack
    busWrite(CTRL, 8'hC0);
    pinN = 1'b0; tick(4);
    irqChk("R9 edge sets request", 1'b1);
    pinN = 1'b1; tick(4);
    irqChk("R9 pin high keeps pending", 1'b1);
    ackPulse();
    irqChk("R9 ack clears pending", 1'b0);

    // Edge coincident with ack
    pinN = 1'b0; tick(4);
    pinN = 1'b1; tick(4);
    irqChk("R9 pending before coincidence", 1'b1);
    pinN = 1'b0;
    tick(2);
    ackPulse();
    irqChk("R10 edge with ack stays set", 1'b1);
    tick(2);
    ackPulse();
    irqChk("R9 held low pin no new edge", 1'b0);
    pinN = 1'b1; tick(4);

    // Capture while disabled
    busWrite(CTRL, 8'h80);
    pinN = 1'b0; tick(4);
    irqChk("R7 edge mode disabled", 1'b0);
    busWrite(CTRL, 8'hC0);
    irqChk("R11 captured edge shows on enable", 1'b1);
    ackPulse();
    pinN = 1'b1; tick(4);

    // No capture in level mode; reset clears pending
    doReset();
    pinN = 1'b0; tick(4);
    pinN = 1'b1; tick(4);
    irqChk("R8 level released", 1'b0);
    specialMode = 1'b1;
    busWrite(CTRL, 8'hC0);
    irqChk("R12 level edge not captured", 1'b0);
    pinN = 1'b0; tick(4);
    pinN = 1'b1; tick(4);
    irqChk("R9 pending before reset", 1'b1);
    doReset();
    busWrite(CTRL, 8'hC0);
    irqChk("R12 reset clears pending", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule